// File: doc/BRIEF.md
# Configurable GPIO Port Controller

An 8-bit general-purpose I/O port with a small bank of registers on a simple synchronous bus. The bus has an address, a write enable, write data and registered read data. For each pin the bank holds these bits:

- an output latch
- a direction bit
- a pull-device enable
- a polarity bit, which selects both the pull direction and the interrupt edge
- a wired-or (open-drain) mode bit
- a pin-change interrupt enable
- a pin-change interrupt flag

The pin inputs pass through a two-flop synchronizer. All reads and all edge detection work on the synchronized value.

The block drives pad controls for each pin: output value, output enable, pull-up enable and pull-down enable. A per-pin peripheral-override input takes a pin away from GPIO use. While the override is set, the pad follows the peripheral's own value and enable, and the GPIO direction bit no longer controls the pad. The direction bit still chooses what a read of the output latch returns. Configuration writes are accepted at any time but only act in the modes where they apply. For example, a push-pull output never has a pull device switched on.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0, so all pins are inputs with pulls off and interrupts masked. The pad output enables, pad outputs, pull enables and `irq` are all 0.
- R2: Reading offset 0 (the output latch) returns, bit by bit, the synchronized pin where the direction bit is 0 and the latched value where it is 1. This holds even while the peripheral override is set.
- R3: Offset 1 always reads the synchronized pin state, whatever the configuration. Writes to offset 1 are ignored.
- R4: A GPIO pin with direction 1 and wired-or mode 0 drives `pad_out` = latch bit with `pad_oe` = 1. Both of its pull enables are 0, whatever its pull-enable bit says.
- R5: A GPIO pin with direction 0 has `pad_oe` = 0 and `pad_out` = 0. A latch value written meanwhile is stored but not driven.
- R6: Where a pull is allowed (pad not actively driven push-pull), pull-enable 1 with polarity 0 raises `pad_pu`, and with polarity 1 raises `pad_pd`. The two are never high together.
- R7: A GPIO output in wired-or mode has `pad_out` = 0. It has `pad_oe` = 1 when its latch bit is 0 and `pad_oe` = 0 when its latch bit is 1. Pulls stay allowed in this mode.
- R8: A pin with `periph_sel` set drives `pad_out` = `periph_out` and `pad_oe` = `periph_oe`, whatever its direction or wired-or bits. Its pulls are suppressed while `periph_oe` is 1.
- R9: A pin's flag (offset 7) is set by a falling edge of the synchronized pin when its polarity bit is 0, and by a rising edge when its polarity bit is 1. The flag is set on the third rising clock edge after the pin changes.
- R10: Writing 1 to a bit of offset 7 clears that flag, and writing 0 leaves it alone. If an edge sets a flag in the same cycle that a write clears it, the flag ends up set.
- R11: `irq` is 1 exactly when some flag bit and its enable bit (offset 6) are both 1. It follows the flags one cycle later.
- R12: The register offsets are: 0 output latch, 1 pin input, 2 direction, 3 pull enable, 4 polarity, 5 wired-or, 6 interrupt enable, 7 interrupt flag. Offsets 2 to 6 read back what was written. `bus_rdata` reflects the address presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pad input levels |
| periph_sel | input | 8 | Per-pin peripheral override |
| periph_out | input | 8 | Peripheral output value |
| periph_oe | input | 8 | Peripheral output enable |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_pd | output | 8 | Pad pull-down enable |
| irq | output | 1 | Pin-change interrupt request |

## Verification
Edge detection can set a flag in the same cycle that a bus write to offset 7 clears it. The bench provokes this by changing a pin on a falling clock edge and then issuing the clearing write so that it lands on the third rising edge. That edge is the one on which the flag is captured. The bench reads the flag afterwards and expects it still set; in a separate case, a clearing write with no edge present must leave the flag clear.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LATCH    = 3'd0,
    REG_PINS     = 3'd1,
    REG_DIR      = 3'd2,
    REG_PULL_EN  = 3'd3,
    REG_POLARITY = 3'd4,
    REG_WOR      = 3'd5,
    REG_IRQ_EN   = 3'd6,
    REG_IRQ_FLAG = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      sync_pin,
  input  logic [W-1:0]      flag_q,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pen_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      wor_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      flag_clr
);
  reg_sel_e     sel;
  logic [W-1:0] rd_mux;

  assign sel      = reg_sel_e'(bus_addr);
  assign flag_clr = (bus_we && sel == REG_IRQ_FLAG) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      pen_q   <= '0;
      pol_q   <= '0;
      wor_q   <= '0;
      ien_q   <= '0;
    end else if (bus_we) begin
      case (sel)
        REG_LATCH:    latch_q <= bus_wdata;
        REG_DIR:      dir_q   <= bus_wdata;
        REG_PULL_EN:  pen_q   <= bus_wdata;
        REG_POLARITY: pol_q   <= bus_wdata;
        REG_WOR:      wor_q   <= bus_wdata;
        REG_IRQ_EN:   ien_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_LATCH:    rd_mux = (dir_q & latch_q) | (~dir_q & sync_pin);
      REG_PINS:     rd_mux = sync_pin;
      REG_DIR:      rd_mux = dir_q;
      REG_PULL_EN:  rd_mux = pen_q;
      REG_POLARITY: rd_mux = pol_q;
      REG_WOR:      rd_mux = wor_q;
      REG_IRQ_EN:   rd_mux = ien_q;
      default:      rd_mux = flag_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_pin,
  input  logic [W-1:0] pol_q,
  input  logic [W-1:0] ien_q,
  input  logic [W-1:0] flag_clr,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] flag_q,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  assign rise     = sync_pin & ~prev_q;
  assign fall     = ~sync_pin & prev_q;
  assign edge_hit = (pol_q & rise) | (~pol_q & fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      prev_q <= sync_pin;
      flag_q <= (flag_q & ~flag_clr) | edge_hit;
      irq    <= |(flag_q & ien_q);
    end
  end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pen_q,
  input  logic [W-1:0] pol_q,
  input  logic [W-1:0] wor_q,
  input  logic [W-1:0] periph_sel,
  input  logic [W-1:0] periph_out,
  input  logic [W-1:0] periph_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_pd
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic out_d, oe_d, pull_ok;

    always_comb begin
      if (periph_sel[i]) begin
        out_d   = periph_out[i];
        oe_d    = periph_oe[i];
        pull_ok = ~periph_oe[i];
      end else if (dir_q[i] && wor_q[i]) begin
        out_d   = 1'b0;
        oe_d    = ~latch_q[i];
        pull_ok = 1'b1;
      end else if (dir_q[i]) begin
        out_d   = latch_q[i];
        oe_d    = 1'b1;
        pull_ok = 1'b0;
      end else begin
        out_d   = 1'b0;
        oe_d    = 1'b0;
        pull_ok = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
        pad_pu[i]  <= 1'b0;
        pad_pd[i]  <= 1'b0;
      end else begin
        pad_out[i] <= out_d;
        pad_oe[i]  <= oe_d;
        pad_pu[i]  <= pull_ok & pen_q[i] & ~pol_q[i];
        pad_pd[i]  <= pull_ok & pen_q[i] & pol_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  input  logic [W-1:0]      periph_sel,
  input  logic [W-1:0]      periph_out,
  input  logic [W-1:0]      periph_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_pu,
  output logic [W-1:0]      pad_pd,
  output logic              irq
);
  logic [W-1:0] sync_pin;
  logic [W-1:0] latch_q, dir_q, pen_q, pol_q, wor_q, ien_q;
  logic [W-1:0] flag_q, flag_clr, edge_hit;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_pin)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_pin(sync_pin),
    .flag_q(flag_q), .latch_q(latch_q), .dir_q(dir_q), .pen_q(pen_q),
    .pol_q(pol_q), .wor_q(wor_q), .ien_q(ien_q), .flag_clr(flag_clr)
  );

  gpio_edge_irq #(.W(W)) u_edge (
    .clk(clk), .rst(rst), .sync_pin(sync_pin), .pol_q(pol_q),
    .ien_q(ien_q), .flag_clr(flag_clr), .edge_hit(edge_hit),
    .flag_q(flag_q), .irq(irq)
  );

  gpio_pad_ctl #(.W(W)) u_pad (
    .clk(clk), .rst(rst), .latch_q(latch_q), .dir_q(dir_q), .pen_q(pen_q),
    .pol_q(pol_q), .wor_q(wor_q), .periph_sel(periph_sel),
    .periph_out(periph_out), .periph_oe(periph_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] periph_sel,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_pu,
  input logic [W-1:0] pad_pd,
  input logic         irq,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] wor_q,
  input logic [W-1:0] ien_q,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] edge_hit,
  input logic [W-1:0] sync_pin
);
  // R3
  pin_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_addr == 3'd1 |=> bus_rdata == $past(sync_pin));

  // R5
  input_undriven_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_oe & $past(~periph_sel & ~dir_q)) == '0);

  // R6
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);

  // R7
  wor_low_only_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_out & $past(~periph_sel & dir_q & wor_q)) == '0);

  // R9
  flag_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_q & ~$past(flag_q) & ~$past(edge_hit)) == '0);

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    edge_hit != '0 |=> (flag_q & $past(edge_hit)) == $past(edge_hit));

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ien_q == '0 |=> !irq);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .periph_sel(periph_sel), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq), .dir_q(dir_q),
  .wor_q(wor_q), .ien_q(ien_q), .flag_q(flag_q), .edge_hit(edge_hit),
  .sync_pin(sync_pin)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0, periph_sel = '0, periph_out = '0, periph_oe = '0;
  logic [7:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic       irq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_latch = 0, m_dir = 0, m_pen = 0, m_pol = 0, m_wor = 0, m_ien = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .periph_sel(periph_sel), .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .irq(irq)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  // Pad model built from the requirements.
  function automatic logic [31:0] exp_pads();
    logic [7:0] o = 0, e = 0, u = 0, dn = 0;
    for (int i = 0; i < 8; i++) begin
      logic ok;
      if (periph_sel[i]) begin
        o[i] = periph_out[i]; e[i] = periph_oe[i]; ok = !periph_oe[i];   // R8
      end else if (m_dir[i] && m_wor[i]) begin
        o[i] = 0; e[i] = !m_latch[i]; ok = 1;                            // R7
      end else if (m_dir[i]) begin
        o[i] = m_latch[i]; e[i] = 1; ok = 0;                             // R4
      end else begin
        o[i] = 0; e[i] = 0; ok = 1;                                      // R5
      end
      u[i]  = ok && m_pen[i] && !m_pol[i];                               // R6
      dn[i] = ok && m_pen[i] && m_pol[i];
    end
    return {o, e, u, dn};
  endfunction

  task automatic check_pads(string tag);
    logic [31:0] x = exp_pads();
    check({tag, " pad_out"}, pad_out, x[31:24]);
    check({tag, " pad_oe"},  pad_oe,  x[23:16]);
    check({tag, " pad_pu"},  pad_pu,  x[15:8]);
    check({tag, " pad_pd"},  pad_pd,  x[7:0]);
  endtask

  task automatic set_pins(logic [7:0] p);
    m_flag |= (m_pol & p & ~pin_in) | (~m_pol & ~p & pin_in);
    @(negedge clk);
    pin_in = p;
  endtask

  task automatic check_regs(string tag);
    logic [7:0] v;
    rd(3'd0, v); check({tag, " R2 latch read"}, v, (m_dir & m_latch) | (~m_dir & pin_in));
    rd(3'd1, v); check({tag, " R3 pin read"}, v, pin_in);
    rd(3'd7, v); check({tag, " R9 flags"}, v, m_flag);
    @(negedge clk);
    check({tag, " R11 irq"}, {7'd0, irq}, {7'd0, |(m_flag & m_ien)});
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check("R1 irq after reset", {7'd0, irq}, 8'd0);
    check("R1 pad_oe after reset", pad_oe, 8'd0);
    check("R1 pulls after reset", pad_pu | pad_pd, 8'd0);
    for (int a = 2; a < 8; a++) begin
      rd(a[2:0], v); check("R1 register reset value", v, 8'd0);
    end

    // R12: readback and ignored write to offset 1
    wr(3'd1, 8'hFF); rd(3'd1, v); check("R12/R3 pin reg write ignored", v, 8'h00);
    wr(3'd4, 8'h3C); m_pol = 8'h3C; rd(3'd4, v); check("R12 polarity readback", v, 8'h3C);
    wr(3'd4, 8'h00); m_pol = 0;

    // R5: input with stored latch
    wr(3'd0, 8'hA5); m_latch = 8'hA5; settle(); check_pads("R5 input");
    rd(3'd0, v); check("R2 input reads pins", v, 8'h00);

    // R4 and R6: push-pull output suppresses pulls
    wr(3'd3, 8'hFF); m_pen = 8'hFF;
    wr(3'd2, 8'hFF); m_dir = 8'hFF; settle(); check_pads("R4 push-pull");
    rd(3'd0, v); check("R2 output reads latch", v, 8'hA5);

    // R7: wired-or
    wr(3'd5, 8'h0F); m_wor = 8'h0F;
    wr(3'd4, 8'hF0); m_pol = 8'hF0; settle(); check_pads("R7 wired-or");

    // R8: peripheral override; direction still picks read source (R2)
    @(negedge clk); periph_sel = 8'hC3; periph_out = 8'h81; periph_oe = 8'h41;
    settle(); check_pads("R8 override");
    rd(3'd0, v); check("R2 latch read under override", v, 8'hA5);
    @(negedge clk); periph_sel = 0; periph_out = 0; periph_oe = 0;

    // R9/R11: falling edges with polarity 0 on low nibble
    wr(3'd4, 8'h00); m_pol = 0;
    set_pins(8'hFF); settle();
    wr(3'd7, 8'hFF); m_flag = 0;
    set_pins(8'hF0); settle();
    check_regs("R9 falling");
    wr(3'd6, 8'h02); m_ien = 8'h02; settle();
    check_regs("R11 enabled");
    // R10: clear with no edge present
    wr(3'd7, 8'h02); m_flag &= ~8'h02; settle();
    check_regs("R10 w1c");

    // R10: set and clear in the same cycle -> set wins
    @(negedge clk); pin_in = 8'hF2;    // rising on bit 1
    wr(3'd4, 8'h02); m_pol = 8'h02;    // (polarity set before the edge reaches detection)
    @(negedge clk); pin_in = 8'hF0;
    @(negedge clk); pin_in = 8'hF2;
    @(posedge clk); @(posedge clk);
    wr(3'd7, 8'h02);                   // lands on the capture edge
    m_flag |= 8'h02;
    settle();
    rd(3'd7, v); check("R10 set wins over clear", v & 8'h02, 8'h02);
    m_flag = v;
    wr(3'd7, 8'hFF); m_flag = 0;

    // Constrained random
    void'($urandom(32'h1234_5678));
    for (int it = 0; it < 250; it++) begin
      logic [7:0] r;
      r = 8'($urandom()); wr(3'd0, r); m_latch = r;
      r = 8'($urandom()); wr(3'd2, r); m_dir = r;
      r = 8'($urandom()); wr(3'd3, r); m_pen = r;
      r = 8'($urandom()); wr(3'd4, r); m_pol = r;
      r = 8'($urandom()); wr(3'd5, r); m_wor = r;
      r = 8'($urandom()); wr(3'd6, r); m_ien = r;
      settle();
      r = 8'($urandom()); wr(3'd7, r); m_flag &= ~r;
      @(negedge clk);
      periph_sel = 8'($urandom()) & 8'($urandom());
      periph_out = 8'($urandom());
      periph_oe  = 8'($urandom());
      set_pins(8'($urandom()));
      settle();
      check_pads("R4-R8 random");
      check_regs("random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule